// File: doc/BRIEF.md
# Link Crossbar Configuration Controller

This block is the control side of a 32-port serial-link crossbar. Each port has an input side and an output side, and any input may be routed to any output. The block takes a stream of command bytes on a valid/ready byte port. Each command is an opcode byte, followed by zero, one or two operand bytes. From these commands the block keeps a connection table. For every output the table holds a source-input number and a connected flag. The active copy of the table drives the select and enable vectors of the switching fabric directly.

Edits go into a shadow table and reach the fabric only when a commit command arrives. A whole new topology can therefore be loaded while the old one keeps running. A query command returns one answer byte on a valid/ready response port. While that byte is waiting, the command port stalls.

A single parser state machine reads the command stream. Its states are:

- `ST_OPCODE`: waits for an opcode.
- `ST_OPND_A`: first operand.
- `ST_OPND_B`: second operand.
- `ST_REPLY`: answer byte pending.

Its transitions are:

- `ST_OPCODE` to `ST_OPND_A` on an opcode that takes operands.
- `ST_OPCODE` back to itself on commit, clear, or a discarded byte.
- `ST_OPND_A` to `ST_OPND_B` for the two-operand opcodes.
- `ST_OPND_A` to `ST_OPCODE` for a single-output disconnect.
- `ST_OPND_A` to `ST_REPLY` for a query.
- `ST_OPND_B` to `ST_OPCODE` once the edit is applied.
- `ST_REPLY` to `ST_OPCODE` when the answer byte is taken.

Top module: `xbar_cfg_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `en_o` and `sel_o` are all zero, `rsp_valid` is 0 and `cmd_ready` is 1.
- R2: Opcode 0x00, with operands (input, output), writes "connected from input" into the shadow entry of that output. The fabric outputs do not change before a commit.
- R3: Opcode 0x03 copies the shadow table to the active table. `en_o` and `sel_o` show the copy in the cycle after the opcode is accepted, and change at no other time except under R7.
- R4: Opcode 0x01, with operands (p, q), sets the shadow entry of output q to source p and the shadow entry of output p to source q.
- R5: Opcode 0x05, with one operand (output), marks that shadow entry unconnected and sets its source to 0.
- R6: Opcode 0x06, with operands (p, q), clears shadow output q only if it is connected from p, and clears shadow output p only if it is connected from q. Other entries are untouched.
- R7: Opcode 0x04 clears both tables. `en_o` and `sel_o` are zero in the next cycle, and a later commit still gives an empty fabric.
- R8: Opcode 0x02, with one operand (output), reads the active table. From the cycle after the operand is accepted, `rsp_valid` is 1. The answer byte is 0x80 OR the source number (bits 4:0) when the output is connected, and 0x00 when it is not.
- R9: While `rsp_valid` is 1, `cmd_ready` is 0 and `rsp_data` holds steady. After the answer is taken, `cmd_ready` returns to 1 in the next cycle.
- R10: Only bits 4:0 of an operand byte select a port. Bits 7:5 have no effect.
- R11: An opcode byte above 0x06 is dropped with no table change, and the byte after it is taken as an opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_data | input | 8 | Command byte (opcode or operand) |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Command byte accepted this cycle when valid |
| rsp_data | output | 8 | Query answer byte |
| rsp_valid | output | 1 | Answer byte present |
| rsp_ready | input | 1 | Answer byte taken this cycle when valid |
| sel_o | output | 160 | Source input per output, 5 bits per output, output k at bits 5k+4:5k |
| en_o | output | 32 | Connected flag per output |

## Verification
Every result is due one clock edge after the byte that causes it is accepted:

- A commit or clear shows on `en_o` and `sel_o` after that edge.
- A query answer appears after the edge that accepts its operand.
- `cmd_ready` recovers one edge after the answer handshake.
- Shadow-only edits must leave the fabric unchanged in every cycle until a commit.

The bench keeps a behavioural model that is advanced on the same rising edge as the design. It compares all outputs at the falling edge that follows, so each result is checked in exactly the cycle it is due. Directed query checks also compare the answer byte against values worked out by hand at that same falling edge.

// File: rtl/xbar_cfg_pkg.sv
`timescale 1ns/1ps
package xbar_cfg_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        XOP_ROUTE  = 3'd0,
        XOP_PAIR   = 3'd1,
        XOP_QUERY  = 3'd2,
        XOP_COMMIT = 3'd3,
        XOP_CLEAR  = 3'd4,
        XOP_DROP   = 3'd5,
        XOP_UNPAIR = 3'd6,
        XOP_BAD    = 3'd7
    } xop_e;

    typedef enum logic [1:0] {
        ST_OPCODE,
        ST_OPND_A,
        ST_OPND_B,
        ST_REPLY
    } pstate_e;

    typedef enum logic [2:0] {
        TA_NONE,
        TA_ROUTE,
        TA_PAIR,
        TA_DROP,
        TA_UNPAIR,
        TA_COMMIT,
        TA_CLEAR
    } tact_e;
endpackage

// File: rtl/xbar_cmd_parser.sv
`timescale 1ns/1ps
module xbar_cmd_parser
    import xbar_cfg_pkg::*;
#(
    parameter int PW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] cmd_data,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    output logic [BYTE_W-1:0] rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output tact_e             act_o,
    output logic [PW-1:0]     a_o,
    output logic [PW-1:0]     b_o,
    output logic [PW-1:0]     qry_idx_o,
    input  logic              qry_en_i,
    input  logic [PW-1:0]     qry_sel_i,
    output logic              opc_phase_o
);
    pstate_e           st_q, st_d;
    xop_e              op_q, op_d;
    logic [PW-1:0]     a_q, a_d;
    logic [BYTE_W-1:0] rsp_q, rsp_d;
    logic              fire;
    logic              op_ok;
    logic [PW-1:0]     opnd;

    assign cmd_ready   = (st_q != ST_REPLY);
    assign rsp_valid   = (st_q == ST_REPLY);
    assign rsp_data    = rsp_q;
    assign opc_phase_o = (st_q == ST_OPCODE);
    assign fire        = cmd_valid && cmd_ready;
    assign opnd        = cmd_data[PW-1:0];
    assign op_ok       = (cmd_data[BYTE_W-1:3] == '0) && (cmd_data[2:0] != XOP_BAD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OPCODE;
            op_q  <= XOP_ROUTE;
            a_q   <= '0;
            rsp_q <= '0;
        end else begin
            st_q  <= st_d;
            op_q  <= op_d;
            a_q   <= a_d;
            rsp_q <= rsp_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d      = st_q;
        op_d      = op_q;
        a_d       = a_q;
        rsp_d     = rsp_q;
        act_o     = TA_NONE;
        a_o       = a_q;
        b_o       = opnd;
        qry_idx_o = opnd;
        unique case (st_q)
            ST_OPCODE: begin
                if (fire && op_ok) begin
                    op_d = xop_e'(cmd_data[2:0]);
                    if (cmd_data[2:0] == XOP_COMMIT) begin
                        act_o = TA_COMMIT;
                    end else if (cmd_data[2:0] == XOP_CLEAR) begin
                        act_o = TA_CLEAR;
                    end else begin
                        st_d = ST_OPND_A;
                    end
                end
            end
            ST_OPND_A: begin
                if (fire) begin
                    a_d = opnd;
                    if (op_q == XOP_QUERY) begin
                        rsp_d = '0;
                        if (qry_en_i) begin
                            rsp_d[BYTE_W-1] = 1'b1;
                            rsp_d[PW-1:0]   = qry_sel_i;
                        end
                        st_d = ST_REPLY;
                    end else if (op_q == XOP_DROP) begin
                        act_o = TA_DROP;
                        a_o   = opnd;
                        st_d  = ST_OPCODE;
                    end else begin
                        st_d = ST_OPND_B;
                    end
                end
            end
            ST_OPND_B: begin
                if (fire) begin
                    case (op_q)
                        XOP_ROUTE:  act_o = TA_ROUTE;
                        XOP_PAIR:   act_o = TA_PAIR;
                        XOP_UNPAIR: act_o = TA_UNPAIR;
                        default:    act_o = TA_NONE;
                    endcase
                    st_d = ST_OPCODE;
                end
            end
            ST_REPLY: begin
                if (rsp_ready) begin
                    st_d = ST_OPCODE;
                end
            end
        endcase
    end
endmodule

// File: rtl/xbar_route_table.sv
`timescale 1ns/1ps
module xbar_route_table
    import xbar_cfg_pkg::*;
#(
    parameter int NPORT = 32,
    parameter int PW    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  tact_e               act_i,
    input  logic [PW-1:0]       a_i,
    input  logic [PW-1:0]       b_i,
    input  logic [PW-1:0]       qry_idx_i,
    output logic                qry_en_o,
    output logic [PW-1:0]       qry_sel_o,
    output logic [NPORT*PW-1:0] sel_o,
    output logic [NPORT-1:0]    en_o
);
    logic [NPORT-1:0] ac_en;
    logic [NPORT*PW-1:0] ac_sel;

    for (genvar i = 0; i < NPORT; i++) begin : g_ent
        localparam logic [PW-1:0] IDX = PW'(i);
        logic          sh_en_q, ac_en_q;
        logic [PW-1:0] sh_sel_q, ac_sel_q;
        logic          unpair_hit;

        assign unpair_hit = sh_en_q &&
                            (((IDX == b_i) && (sh_sel_q == a_i)) ||
                             ((IDX == a_i) && (sh_sel_q == b_i)));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_en_q  <= 1'b0;
                sh_sel_q <= '0;
                ac_en_q  <= 1'b0;
                ac_sel_q <= '0;
            end else begin
                case (act_i)
                    TA_CLEAR: begin
                        sh_en_q  <= 1'b0;
                        sh_sel_q <= '0;
                        ac_en_q  <= 1'b0;
                        ac_sel_q <= '0;
                    end
                    TA_COMMIT: begin
                        ac_en_q  <= sh_en_q;
                        ac_sel_q <= sh_sel_q;
                    end
                    TA_ROUTE: begin
                        if (IDX == b_i) begin
                            sh_en_q  <= 1'b1;
                            sh_sel_q <= a_i;
                        end
                    end
                    TA_PAIR: begin
                        if (IDX == b_i) begin
                            sh_en_q  <= 1'b1;
                            sh_sel_q <= a_i;
                        end else if (IDX == a_i) begin
                            sh_en_q  <= 1'b1;
                            sh_sel_q <= b_i;
                        end
                    end
                    TA_DROP: begin
                        if (IDX == a_i) begin
                            sh_en_q  <= 1'b0;
                            sh_sel_q <= '0;
                        end
                    end
                    TA_UNPAIR: begin
                        if (unpair_hit) begin
                            sh_en_q  <= 1'b0;
                            sh_sel_q <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end

        assign ac_en[i]             = ac_en_q;
        assign ac_sel[i*PW +: PW]   = ac_sel_q;
    end

    assign en_o      = ac_en;
    assign sel_o     = ac_sel;
    assign qry_en_o  = ac_en[qry_idx_i];
    assign qry_sel_o = ac_sel[qry_idx_i*PW +: PW];
endmodule

// File: rtl/xbar_cfg_ctrl.sv
`timescale 1ns/1ps
module xbar_cfg_ctrl
    import xbar_cfg_pkg::*;
#(
    parameter int NPORT = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [7:0]                   cmd_data,
    input  logic                         cmd_valid,
    output logic                         cmd_ready,
    output logic [7:0]                   rsp_data,
    output logic                         rsp_valid,
    input  logic                         rsp_ready,
    output logic [NPORT*$clog2(NPORT)-1:0] sel_o,
    output logic [NPORT-1:0]             en_o
);
    localparam int PW = $clog2(NPORT);

    tact_e         act;
    logic [PW-1:0] a_sel, b_sel, qry_idx, qry_sel;
    logic          qry_en;
    logic          opc_phase;

    xbar_cmd_parser #(.PW(PW)) u_parser (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_data    (cmd_data),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .rsp_data    (rsp_data),
        .rsp_valid   (rsp_valid),
        .rsp_ready   (rsp_ready),
        .act_o       (act),
        .a_o         (a_sel),
        .b_o         (b_sel),
        .qry_idx_o   (qry_idx),
        .qry_en_i    (qry_en),
        .qry_sel_i   (qry_sel),
        .opc_phase_o (opc_phase)
    );

    xbar_route_table #(.NPORT(NPORT), .PW(PW)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_i     (act),
        .a_i       (a_sel),
        .b_i       (b_sel),
        .qry_idx_i (qry_idx),
        .qry_en_o  (qry_en),
        .qry_sel_o (qry_sel),
        .sel_o     (sel_o),
        .en_o      (en_o)
    );
endmodule

// File: rtl/xbar_cfg_chk.sv
`timescale 1ns/1ps
module xbar_cfg_chk #(
    parameter int NPORT = 32,
    parameter int PW    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic [7:0]          cmd_data,
    input logic                cmd_valid,
    input logic                cmd_ready,
    input logic [7:0]          rsp_data,
    input logic                rsp_valid,
    input logic                rsp_ready,
    input logic [NPORT*PW-1:0] sel_o,
    input logic [NPORT-1:0]    en_o,
    input logic                opc_phase
);
    p_reply_blocks_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready);

    p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    p_rsp_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_data[7]) |-> (rsp_data == 8'h00));

    p_rsp_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((({1'b0, rsp_data[6:0]}) >> PW) == 8'h00));

    p_rsp_after_operand_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(cmd_valid && cmd_ready && !opc_phase));

    p_fabric_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_ready && opc_phase && (cmd_data == 8'd3 || cmd_data == 8'd4))
        |=> ($stable(en_o) && $stable(sel_o)));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && opc_phase && cmd_data == 8'd4)
        |=> (en_o == '0 && sel_o == '0));

    p_bad_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && opc_phase && cmd_data > 8'd6) |=> opc_phase);
endmodule

bind xbar_cfg_ctrl xbar_cfg_chk #(.NPORT(NPORT), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_data  (cmd_data),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .rsp_data  (rsp_data),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .sel_o     (sel_o),
    .en_o      (en_o),
    .opc_phase (opc_phase)
);

// File: tb/xbar_cfg_ctrl_tb_top.sv
`timescale 1ns/1ps
module xbar_cfg_ctrl_tb_top;
    localparam int NP = 32;
    localparam int PB = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      cmd_data = 8'h00;
    logic            cmd_valid = 1'b0;
    logic            cmd_ready;
    logic [7:0]      rsp_data;
    logic            rsp_valid;
    logic            rsp_ready = 1'b1;
    logic [NP*PB-1:0] sel_o;
    logic [NP-1:0]   en_o;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    cmp_on = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference model
    int   m_phase = 0;
    int   m_op = 0;
    int   m_a = 0;
    bit   m_rv = 0;
    int   m_rd = 0;
    bit   m_fire;
    int   m_sh_en[NP];
    int   m_sh_sel[NP];
    int   m_ac_en[NP];
    int   m_ac_sel[NP];

    always #2 clk = ~clk;

    xbar_cfg_ctrl #(.NPORT(NP)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_data  (cmd_data),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .rsp_data  (rsp_data),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .sel_o     (sel_o),
        .en_o      (en_o)
    );

    task automatic model_clear_all();
        for (int i = 0; i < NP; i++) begin
            m_sh_en[i] = 0; m_sh_sel[i] = 0; m_ac_en[i] = 0; m_ac_sel[i] = 0;
        end
    endtask

    task automatic model_byte(input int b);
        int c;
        bit hit_c, hit_a;
        c = b & 31;
        case (m_phase)
            0: begin
                m_op = b;
                if (b == 0 || b == 1 || b == 2 || b == 5 || b == 6) m_phase = 1;
                else if (b == 3) begin
                    for (int i = 0; i < NP; i++) begin
                        m_ac_en[i] = m_sh_en[i]; m_ac_sel[i] = m_sh_sel[i];
                    end
                end else if (b == 4) model_clear_all();
            end
            1: begin
                m_a = c;
                if (m_op == 2) begin
                    m_rd = m_ac_en[c] ? (8'h80 | m_ac_sel[c]) : 0;
                    m_rv = 1; m_phase = 3;
                end else if (m_op == 5) begin
                    m_sh_en[c] = 0; m_sh_sel[c] = 0; m_phase = 0;
                end else m_phase = 2;
            end
            2: begin
                if (m_op == 0) begin
                    m_sh_en[c] = 1; m_sh_sel[c] = m_a;
                end else if (m_op == 1) begin
                    m_sh_en[c] = 1; m_sh_sel[c] = m_a;
                    m_sh_en[m_a] = 1; m_sh_sel[m_a] = c;
                end else begin
                    hit_c = m_sh_en[c] && m_sh_sel[c] == m_a;
                    hit_a = m_sh_en[m_a] && m_sh_sel[m_a] == c;
                    if (hit_c) begin m_sh_en[c] = 0; m_sh_sel[c] = 0; end
                    if (hit_a) begin m_sh_en[m_a] = 0; m_sh_sel[m_a] = 0; end
                end
                m_phase = 0;
            end
            default: ;
        endcase
    endtask

    initial model_clear_all();

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_rv = 0; m_rd = 0; m_op = 0; m_a = 0;
            model_clear_all();
        end else begin
            m_fire = cmd_valid && (m_phase != 3);
            if (m_phase == 3) begin
                if (rsp_ready) begin m_rv = 0; m_phase = 0; end
            end else if (m_fire) model_byte(int'(cmd_data));
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        logic [NP*PB-1:0] e_sel;
        logic [NP-1:0]    e_en;
        if (cmp_on) begin
            for (int i = 0; i < NP; i++) begin
                e_en[i] = m_ac_en[i][0];
                e_sel[i*PB +: PB] = m_ac_sel[i][PB-1:0];
            end
            chk(cur_req, "cmd_ready", 256'(cmd_ready), 256'(m_phase != 3));
            chk(cur_req, "rsp_valid", 256'(rsp_valid), 256'(m_rv));
            chk(cur_req, "en_o", 256'(en_o), 256'(e_en));
            chk(cur_req, "sel_o", 256'(sel_o), 256'(e_sel));
            if (m_rv) chk(cur_req, "rsp_data", 256'(rsp_data), 256'(m_rd[7:0]));
        end
    end

    task automatic send(input logic [7:0] b);
        cmd_data  = b;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic query(input logic [7:0] p, input logic [7:0] exp, input string tag);
        send(8'h02);
        send(p);
        chk(tag, "query valid", 256'(rsp_valid), 256'(1));
        chk(tag, "query byte", 256'(rsp_data), 256'(exp));
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        @(posedge clk);
        cmp_on = 1;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "en_o reset", 256'(en_o), 256'(0));
        chk("R1", "cmd_ready reset", 256'(cmd_ready), 256'(1));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rsp_valid after reset", 256'(rsp_valid), 256'(0));

        // R2: shadow-only route, fabric unchanged
        cur_req = "R2";
        send(8'h00); send(8'd3); send(8'd7);
        chk("R2", "en_o before commit", 256'(en_o), 256'(0));

        // R3: commit
        cur_req = "R3";
        send(8'h03);
        chk("R3", "en_o[7] after commit", 256'(en_o[7]), 256'(1));
        chk("R3", "sel out7", 256'(sel_o[7*PB +: PB]), 256'(3));

        // R4: pair connect
        cur_req = "R4";
        send(8'h01); send(8'd10); send(8'd20);
        send(8'h03);
        chk("R4", "sel out20", 256'(sel_o[20*PB +: PB]), 256'(10));
        chk("R4", "sel out10", 256'(sel_o[10*PB +: PB]), 256'(20));

        // R8: queries
        cur_req = "R8";
        query(8'd20, 8'h8A, "R8");
        query(8'd5, 8'h00, "R8");

        // R10: high operand bits ignored
        cur_req = "R10";
        send(8'h00); send(8'hE2); send(8'hBF);
        send(8'h03);
        chk("R10", "sel out31", 256'(sel_o[31*PB +: PB]), 256'(2));
        query(8'hFF, 8'h82, "R10");

        // R5: single disconnect
        cur_req = "R5";
        send(8'h05); send(8'd7); send(8'h03);
        chk("R5", "en_o[7] dropped", 256'(en_o[7]), 256'(0));
        query(8'd7, 8'h00, "R5");

        // R6: pair disconnect, matching and non-matching
        cur_req = "R6";
        send(8'h06); send(8'd20); send(8'd10);
        send(8'h06); send(8'd3); send(8'd31);
        send(8'h03);
        chk("R6", "out10/out20 cleared", 256'({en_o[10], en_o[20]}), 256'(0));
        chk("R6", "out31 kept", 256'(en_o[31]), 256'(1));

        // R11: bad opcodes dropped
        cur_req = "R11";
        send(8'h07); send(8'h00); send(8'd1); send(8'd2);
        send(8'h95); send(8'h03);
        query(8'd2, 8'h81, "R11");

        // R9: held answer, command port stalled
        cur_req = "R9";
        rsp_ready = 1'b0;
        send(8'h02); send(8'd31);
        send(8'h04);
        chk("R9", "cmd_ready while pending", 256'(cmd_ready), 256'(0));
        chk("R9", "answer held", 256'(rsp_data), 256'(8'h82));
        chk("R9", "byte not taken", 256'(en_o[31]), 256'(1));
        rsp_ready = 1'b1;
        @(negedge clk);
        chk("R9", "cmd_ready back", 256'(cmd_ready), 256'(1));

        // R7: clear both tables
        cur_req = "R7";
        send(8'h00); send(8'd4); send(8'd9);
        send(8'h04);
        chk("R7", "en_o cleared", 256'(en_o), 256'(0));
        send(8'h03);
        chk("R7", "commit after clear", 256'(en_o), 256'(0));

        // mixed traffic against the model
        cur_req = "R2";
        for (int k = 0; k < 600; k++) begin
            int r;
            r = $urandom_range(0, 9);
            rsp_ready = 1'($urandom_range(0, 1));
            if (r < 7) begin
                send(8'(r));
                if (r != 3 && r != 4) send(8'($urandom_range(0, 255)));
                if (r == 0 || r == 1 || r == 6) send(8'($urandom_range(0, 255)));
            end else begin
                send(8'($urandom_range(7, 255)));
            end
        end
        rsp_ready = 1'b1;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule